// File: doc/BRIEF.md
# Shader Program Upload Port

This block lets a host fill two on-chip memories over a narrow register write bus. The memories are a shader instruction store and a separate operand-descriptor store. The host does not send a write address with each word. For each memory it first writes a start offset to a setup register. It then streams words to a data register. Each word is stored at the current offset, and the offset then advances by one. The data register therefore acts like a queue that drains into RAM.

The shader core reads each memory through its own read port, and read data appears one cycle after the address is presented. When the host writes the value 1 to the finish register, the block raises a single-cycle completion pulse and sets a sticky "program loaded" flag. The flag stays set until the next setup write to either memory.

Top module: `shader_prog_loader`

## Requirements
- R1: A host write with `host_sel` = 0 loads the low CODE_AW bits of `host_wdata` into the code offset, and the next code data word is stored at that index.
- R2: Each host write with `host_sel` = 1 stores `host_wdata` in the code memory at the current code offset and then advances that offset by one, so a stream of words fills consecutive indices.
- R3: An offset that advances past the highest index (4095 for code, 127 for descriptors) wraps to 0, and the word that caused the wrap is still written.
- R4: The code memory uses 12-bit indices and holds 4096 independent 32-bit words. Every index from 0 to 4095 can be written and read back.
- R5: The descriptor memory is loaded the same way: `host_sel` = 3 sets its offset, and `host_sel` = 4 stores a word at that offset and advances it.
- R6: The two offsets are independent. Setup or data writes for one memory never change the other memory's offset or contents.
- R7: A host write with `host_sel` = 2 and data exactly 1 produces `load_done` high for exactly one cycle, starting on the clock edge that captures the write, and sets `load_ready`. The same select with any other data value has no effect.
- R8: A setup write (`host_sel` = 0 or 3) clears `load_ready`.
- R9: Each read port is registered. `code_rd_data` and `desc_rd_data` show the word at the address presented one clock edge earlier, and they keep their old value until that edge.
- R10: Writes with `host_sel` = 5, 6 or 7 are ignored, and so is any cycle with `host_we` low. Neither changes an offset, a memory word or a flag.
- R11: A data write in the cycle right after a setup write is stored at the offset that the setup write just loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Register select (0 code setup, 1 code data, 2 finish, 3 descriptor setup, 4 descriptor data) |
| host_wdata | input | 32 | Host write data |
| code_rd_addr | input | 12 | Shader-side code read index |
| code_rd_data | output | 32 | Code word, one cycle after the address |
| desc_rd_addr | input | 7 | Shader-side descriptor read index |
| desc_rd_data | output | 32 | Descriptor word, one cycle after the address |
| load_done | output | 1 | One-cycle completion pulse |
| load_ready | output | 1 | Sticky program-loaded flag |

## Verification
A wrong offset is invisible at the moment it happens. It shows up later, when a word read back from the shader port sits at a different index than the count of writes since the last setup predicts. For that reason the bench fills the whole code memory and reads every index back, so a skipped, doubled or unwrapped increment shows as a mismatch within one read cycle. A missing or stretched completion pulse, or a flag that is not cleared, shows at the ports on the first edge after the finish or setup write. The bench samples there.

// File: rtl/slp_pkg.sv
package slp_pkg;

  // Host register selects; the bench relies on these values.
  typedef enum logic [2:0] {
    SEL_CODE_SETUP = 3'd0,
    SEL_CODE_DATA  = 3'd1,
    SEL_FINISH     = 3'd2,
    SEL_DESC_SETUP = 3'd3,
    SEL_DESC_DATA  = 3'd4
  } host_reg_e;

  // Only the exact value 1 finalizes a load.
  function automatic logic is_finish_value(input logic [31:0] v);
    return v == 32'd1;
  endfunction

endpackage

// File: rtl/slp_decode.sv
module slp_decode
  import slp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              code_setup_we,
  output logic              code_data_we,
  output logic              desc_setup_we,
  output logic              desc_data_we,
  output logic              finish_hit
);

  always_comb begin
    code_setup_we = 1'b0;
    code_data_we  = 1'b0;
    desc_setup_we = 1'b0;
    desc_data_we  = 1'b0;
    finish_hit    = 1'b0;
    if (host_we) begin
      case (host_sel)
        SEL_CODE_SETUP: code_setup_we = 1'b1;
        SEL_CODE_DATA:  code_data_we  = 1'b1;
        SEL_FINISH:     finish_hit    = is_finish_value(32'(host_wdata));
        SEL_DESC_SETUP: desc_setup_we = 1'b1;
        SEL_DESC_DATA:  desc_data_we  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/slp_offset_ctr.sv
module slp_offset_ctr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] offset
);

  // Modulo-depth advance: the top index rolls over to zero.
  function automatic logic [AW-1:0] advance(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    offset <= '0;
    else if (load) offset <= load_val;
    else if (step) offset <= advance(offset);
  end

endmodule

// File: rtl/slp_ram.sv
module slp_ram #(
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/shader_prog_loader.sv
module shader_prog_loader
  import slp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CODE_AW = 12,
  parameter int DESC_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [2:0]         host_sel,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [CODE_AW-1:0] code_rd_addr,
  output logic [DATA_W-1:0]  code_rd_data,
  input  logic [DESC_AW-1:0] desc_rd_addr,
  output logic [DATA_W-1:0]  desc_rd_data,
  output logic               load_done,
  output logic               load_ready
);

  // Named internal events, visible to the bound checker.
  logic               code_setup_we, code_data_we;
  logic               desc_setup_we, desc_data_we;
  logic               finish_hit;
  logic [CODE_AW-1:0] code_off;
  logic [DESC_AW-1:0] desc_off;
  logic               any_setup;

  slp_decode #(.DATA_W(DATA_W)) u_dec (
    .host_we      (host_we),
    .host_sel     (host_sel),
    .host_wdata   (host_wdata),
    .code_setup_we(code_setup_we),
    .code_data_we (code_data_we),
    .desc_setup_we(desc_setup_we),
    .desc_data_we (desc_data_we),
    .finish_hit   (finish_hit)
  );

  slp_offset_ctr #(.AW(CODE_AW)) u_code_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (code_setup_we),
    .step    (code_data_we),
    .load_val(host_wdata[CODE_AW-1:0]),
    .offset  (code_off)
  );

  slp_offset_ctr #(.AW(DESC_AW)) u_desc_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (desc_setup_we),
    .step    (desc_data_we),
    .load_val(host_wdata[DESC_AW-1:0]),
    .offset  (desc_off)
  );

  slp_ram #(.AW(CODE_AW), .DW(DATA_W)) u_code_ram (
    .clk  (clk),
    .we   (code_data_we),
    .waddr(code_off),
    .wdata(host_wdata),
    .raddr(code_rd_addr),
    .rdata(code_rd_data)
  );

  slp_ram #(.AW(DESC_AW), .DW(DATA_W)) u_desc_ram (
    .clk  (clk),
    .we   (desc_data_we),
    .waddr(desc_off),
    .wdata(host_wdata),
    .raddr(desc_rd_addr),
    .rdata(desc_rd_data)
  );

  assign any_setup = code_setup_we | desc_setup_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_done  <= 1'b0;
      load_ready <= 1'b0;
    end else begin
      load_done <= finish_hit;
      if (any_setup)       load_ready <= 1'b0;
      else if (finish_hit) load_ready <= 1'b1;
    end
  end

endmodule

// File: rtl/slp_checker.sv
module slp_checker #(
  parameter int DATA_W  = 32,
  parameter int CODE_AW = 12,
  parameter int DESC_AW = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic [2:0]         host_sel,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [CODE_AW-1:0] code_off,
  input logic [DESC_AW-1:0] desc_off,
  input logic               load_done,
  input logic               load_ready
);

  logic w_code_setup, w_code_data, w_desc_setup, w_desc_data, w_finish;
  assign w_code_setup = host_we && host_sel == 3'd0;
  assign w_code_data  = host_we && host_sel == 3'd1;
  assign w_finish     = host_we && host_sel == 3'd2 && host_wdata == DATA_W'(1);
  assign w_desc_setup = host_we && host_sel == 3'd3;
  assign w_desc_data  = host_we && host_sel == 3'd4;

  p_code_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    w_code_setup |=> code_off == $past(host_wdata[CODE_AW-1:0]));

  p_code_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_code_data |=> code_off == CODE_AW'($past(code_off) + 1'b1));

  p_desc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_desc_data |=> desc_off == DESC_AW'($past(desc_off) + 1'b1));

  p_desc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_code_setup || w_code_data) |=> $stable(desc_off));

  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_desc_setup || w_desc_data) |=> $stable(code_off));

  p_done_after_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_finish |=> load_done && load_ready);

  p_done_only_on_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !w_finish |=> !load_done);

  p_setup_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_code_setup || w_desc_setup) |=> !load_ready);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we || host_sel > 3'd4) |=> $stable(code_off) && $stable(desc_off));

endmodule

bind shader_prog_loader slp_checker #(
  .DATA_W(DATA_W), .CODE_AW(CODE_AW), .DESC_AW(DESC_AW)
) u_slp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_we   (host_we),
  .host_sel  (host_sel),
  .host_wdata(host_wdata),
  .code_off  (code_off),
  .desc_off  (desc_off),
  .load_done (load_done),
  .load_ready(load_ready)
);

// File: tb/test_shader_prog_loader.sv
`timescale 1ns/1ps
module test_shader_prog_loader;

  localparam int CAW = 12;
  localparam int DAW = 7;
  localparam int CDEPTH = 1 << CAW;
  localparam int DDEPTH = 1 << DAW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           host_we = 1'b0;
  logic [2:0]     host_sel = '0;
  logic [31:0]    host_wdata = '0;
  logic [CAW-1:0] code_rd_addr = '0;
  logic [31:0]    code_rd_data;
  logic [DAW-1:0] desc_rd_addr = '0;
  logic [31:0]    desc_rd_data;
  logic           load_done, load_ready;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] exp_code [CDEPTH];
  logic [31:0] exp_desc [DDEPTH];

  always #2 clk = ~clk;

  shader_prog_loader i_shader_prog_loader (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .code_rd_addr(code_rd_addr),
    .code_rd_data(code_rd_data), .desc_rd_addr(desc_rd_addr),
    .desc_rd_data(desc_rd_data), .load_done(load_done), .load_ready(load_ready)
  );

  function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
    return (32'(i) * 32'h9E37_79B1) ^ salt;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd_code(input int a, output logic [31:0] d);
    @(negedge clk); code_rd_addr = CAW'(a);
    @(negedge clk); d = code_rd_data;
  endtask

  task automatic rd_desc(input int a, output logic [31:0] d);
    @(negedge clk); desc_rd_addr = DAW'(a);
    @(negedge clk); d = desc_rd_data;
  endtask

  task automatic sweep_code(input string req);
    logic [31:0] d;
    int bad = 0;
    for (int a = 0; a < CDEPTH; a++) begin
      rd_code(a, d);
      if (d !== exp_code[a]) begin
        bad++;
        if (bad < 4) check(req, d, exp_code[a]);
      end
    end
    check(req, 32'(bad), 32'd0);
  endtask

  task automatic sweep_desc(input string req);
    logic [31:0] d;
    for (int a = 0; a < DDEPTH; a++) begin
      rd_desc(a, d);
      check(req, d, exp_desc[a]);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset load_done", 32'(load_done), 0);
    check("reset load_ready", 32'(load_ready), 0);

    // R4 R1 R2 R11: full code fill from 0, setup then data back to back
    wr(3'd0, 32'h0000_0000);
    for (int i = 0; i < CDEPTH; i++) begin
      exp_code[i] = pat(i, 32'h1357_2468);
      wr(3'd1, exp_code[i]);
    end
    idle();
    sweep_code("R4 R2 full code fill");

    // R1 R11: setup at an offset with upper bits set beyond CAW; data follows at once
    wr(3'd0, 32'hFFFF_F123);
    wr(3'd1, 32'hCAFE_0001); exp_code[12'h123] = 32'hCAFE_0001;
    wr(3'd1, 32'hCAFE_0002); exp_code[12'h124] = 32'hCAFE_0002;
    idle();
    rd_code(12'h123, d); check("R1 R11 first word at setup offset", d, 32'hCAFE_0001);
    rd_code(12'h124, d); check("R2 second word at offset+1", d, 32'hCAFE_0002);
    rd_code(12'h122, d); check("R1 word below offset untouched", d, exp_code[12'h122]);

    // R3: code wrap 4094 -> 4095 -> 0 -> 1
    wr(3'd0, 32'd4094);
    for (int i = 0; i < 4; i++) begin
      exp_code[(4094 + i) % CDEPTH] = pat(i, 32'hAAAA_5555);
      wr(3'd1, pat(i, 32'hAAAA_5555));
    end
    idle();
    rd_code(4095, d); check("R3 code top index", d, exp_code[4095]);
    rd_code(0, d);    check("R3 code wrapped to 0", d, exp_code[0]);
    rd_code(1, d);    check("R3 code after wrap", d, exp_code[1]);

    // R5 R3: full descriptor fill starting at 100, wraps through 127 -> 0
    wr(3'd3, 32'd100);
    for (int i = 0; i < DDEPTH; i++) begin
      exp_desc[(100 + i) % DDEPTH] = pat(i, 32'h0D0D_F00D);
      wr(3'd4, pat(i, 32'h0D0D_F00D));
    end
    idle();
    sweep_desc("R5 R3 descriptor fill with wrap");

    // R6: interleave; code offset continues at 2 after the descriptor traffic
    wr(3'd1, 32'hB0B0_0002); exp_code[2] = 32'hB0B0_0002;
    wr(3'd3, 32'd5);
    wr(3'd4, 32'hD5D5_0005); exp_desc[5] = 32'hD5D5_0005;
    wr(3'd1, 32'hB0B0_0003); exp_code[3] = 32'hB0B0_0003;
    wr(3'd0, 32'd7);
    wr(3'd4, 32'hD5D5_0006); exp_desc[6] = 32'hD5D5_0006;
    idle();
    rd_code(3, d); check("R6 code offset kept across descriptor writes", d, 32'hB0B0_0003);
    rd_desc(6, d); check("R6 desc offset kept across code setup", d, 32'hD5D5_0006);
    rd_code(7, d); check("R6 code untouched by descriptor data", d, exp_code[7]);

    // R10: ignored selects and we low
    wr(3'd5, 32'hDEAD_0005);
    wr(3'd6, 32'hDEAD_0006);
    wr(3'd7, 32'd1);
    idle();
    @(negedge clk); host_sel = 3'd1; host_wdata = 32'hDEAD_BEEF; // we stays low
    check("R10 no done from ignored writes", 32'(load_done), 0);
    wr(3'd1, 32'h7777_0007); exp_code[7] = 32'h7777_0007;
    idle();
    rd_code(7, d); check("R10 code offset not moved by ignored writes", d, 32'h7777_0007);
    rd_code(8, d); check("R10 next index untouched", d, exp_code[8]);

    // R7: finish with wrong values has no effect
    wr(3'd2, 32'd0); idle();
    check("R7 finish value 0 no pulse", 32'(load_done), 0);
    wr(3'd2, 32'd3); idle();
    check("R7 finish value 3 no pulse", 32'(load_done), 0);
    check("R7 finish value 3 no flag", 32'(load_ready), 0);
    wr(3'd2, 32'd1); idle();
    check("R7 done pulse after finish", 32'(load_done), 1);
    check("R7 ready set", 32'(load_ready), 1);
    idle();
    check("R7 done lasts one cycle", 32'(load_done), 0);
    check("R7 ready sticky", 32'(load_ready), 1);
    wr(3'd1, 32'h1111_0008); exp_code[8] = 32'h1111_0008; idle();
    check("R7 ready kept over data write", 32'(load_ready), 1);

    // R8: either setup clears the flag
    wr(3'd3, 32'd0); idle();
    check("R8 descriptor setup clears ready", 32'(load_ready), 0);
    wr(3'd2, 32'd1); idle();
    check("R7 ready set again", 32'(load_ready), 1);
    wr(3'd0, 32'd0); idle();
    check("R8 code setup clears ready", 32'(load_ready), 0);

    // R9: registered read latency
    rd_code(100, d);
    check("R9 read value at 100", d, exp_code[100]);
    @(negedge clk); code_rd_addr = CAW'(200);
    #1 check("R9 data holds before edge", code_rd_data, exp_code[100]);
    @(negedge clk);
    check("R9 data after one edge", code_rd_data, exp_code[200]);

    // Final full sweeps confirm nothing else moved
    sweep_code("R6 R10 final code sweep");
    sweep_desc("R6 final descriptor sweep");

    finished = 1;
    summary();
  end

endmodule